// File: doc/BRIEF.md
# DMA Request Line Endpoint Mapper

This block shares a small pool of DMA request lines among USB endpoints. Each line owns one slot, and each slot holds a field packed into a single map register. A field records which endpoint owns the line and whether the transfer is in the transmit or the receive direction. Software can read the map register and overwrite it through a simple write port. Hardware clients use a command port instead: an allocate command carries an endpoint number and a direction, and it gets back either a slot index or a refusal. A release command frees a slot.

The block has two modes. In multichannel mode any of the five slots can be granted, and the lowest free slot is always chosen first. In single-channel mode only slot 0 is used. A new owner is refused while the register holds anything, and a release must name the endpoint that is stored there. For each occupied slot, the block routes the ready condition of the owning endpoint and direction onto that slot's request line.

Top module: `dma_req_mapper`

## Requirements
- R1: After reset the map register reads zero, every request line is low and no response is valid. Bits 31:25 of the read data always read zero.
- R2: A bus write loads write-data bits 24:0 into the map register, visible on the read data one cycle later. In that cycle the bus write has precedence: an allocate in the same cycle is answered with a refusal, and a release in the same cycle is dropped without an error.
- R3: Slot s occupies bits 5s+4:5s of the map register. Bits 5s+3:5s hold the endpoint number, and bit 5s+4 is 1 for transmit and 0 for receive. A slot is free when its endpoint bits are zero.
- R4: In multichannel mode, an allocate picks the lowest-indexed free slot and writes {direction, endpoint} into it. The response is due the next cycle: rsp_valid=1, rsp_ok=1, and rsp_slot set to that index.
- R5: An allocate that finds no free slot is answered with rsp_valid=1 and rsp_ok=0, and the map register is left unchanged.
- R6: An allocate for endpoint 0 is refused in both modes and changes nothing.
- R7: In multichannel mode, a release clears all five bits of the slot given by rel_slot. A rel_slot of 5 or more raises rel_err for one cycle and changes nothing.
- R8: In single-channel mode, an allocate is granted only when the map register is zero. The grant always returns slot 0, and the field is written at bits 4:0.
- R9: In single-channel mode, a release whose rel_ep equals bits 3:0 of the map register clears the whole register. Any other rel_ep raises rel_err and leaves the register unchanged.
- R10: dma_req[s] is high exactly when slot s is occupied and the ready input of its endpoint is high. The ready input is ep_tx_ready when the direction bit is 1 and ep_rx_ready when it is 0. The output is combinational on the current map and ready inputs.
- R11: A release and an allocate issued in the same cycle are applied in that order, so the slot freed by the release can be granted to the allocate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| multi_mode | input | 1 | 1 selects multichannel mode, 0 selects single-channel mode |
| bus_wr | input | 1 | Write strobe for the map register |
| bus_wdata | input | 32 | Write data; bits 24:0 are used |
| bus_rdata | output | 32 | Current map register contents |
| alloc_req | input | 1 | Allocate command |
| alloc_ep | input | 4 | Endpoint number to allocate for |
| alloc_tx | input | 1 | 1 for transmit, 0 for receive |
| rel_req | input | 1 | Release command |
| rel_slot | input | 3 | Slot to release (multichannel mode) |
| rel_ep | input | 4 | Endpoint that claims ownership (single-channel mode) |
| rsp_valid | output | 1 | Allocate response valid |
| rsp_ok | output | 1 | 1 = granted, 0 = refused, try again later |
| rsp_slot | output | 3 | Granted slot index, zero on refusal |
| rel_err | output | 1 | Release was rejected |
| ep_tx_ready | input | 16 | Per-endpoint transmit ready |
| ep_rx_ready | input | 16 | Per-endpoint receive ready |
| dma_req | output | 5 | Request line per slot |

## Verification
Commands and bus writes are sampled on a rising edge. The response, rel_err and the updated read data all appear right after that same edge, one cycle after the stimulus. The request lines follow the map register and the ready inputs within the same cycle, with no register in between. The bench drives every input on the falling edge. It then compares all outputs at the following falling edge, against a model that it advances once per cycle. This way each result is observed exactly in the cycle it is due, and no result depends on process ordering at the clock edge.

// File: rtl/dma_req_mapper.sv
module dma_req_mapper #(
  parameter int NSLOTS = 5,
  parameter int EPW    = 4,
  parameter int DW     = 32,
  localparam int FW    = EPW + 1,
  localparam int SW    = $clog2(NSLOTS),
  localparam int NEP   = 1 << EPW,
  localparam int MAPW  = NSLOTS * FW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              multi_mode,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              alloc_req,
  input  logic [EPW-1:0]    alloc_ep,
  input  logic              alloc_tx,
  input  logic              rel_req,
  input  logic [SW-1:0]     rel_slot,
  input  logic [EPW-1:0]    rel_ep,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [SW-1:0]     rsp_slot,
  output logic              rel_err,
  input  logic [NEP-1:0]    ep_tx_ready,
  input  logic [NEP-1:0]    ep_rx_ready,
  output logic [NSLOTS-1:0] dma_req
);

  logic [MAPW-1:0]   map_q, after_rel, map_d;
  logic [NSLOTS-1:0] free_vec;
  logic [SW-1:0]     low_free, pick;
  logic              rel_bad, any_free, grant;

  always_comb begin
    after_rel = map_q;
    rel_bad   = 1'b0;
    if (rel_req && !bus_wr) begin
      if (multi_mode) begin
        rel_bad = 1'b1;
        for (int s = 0; s < NSLOTS; s++)
          if (rel_slot == SW'(s)) begin
            after_rel[s*FW +: FW] = '0;
            rel_bad = 1'b0;
          end
      end else if (map_q[EPW-1:0] == rel_ep) begin
        after_rel = '0;
      end else begin
        rel_bad = 1'b1;
      end
    end
  end

  generate
    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      logic [EPW-1:0] own_ep;
      logic           own_tx;
      assign free_vec[s] = (after_rel[s*FW +: EPW] == '0);
      assign own_ep      = map_q[s*FW +: EPW];
      assign own_tx      = map_q[s*FW + EPW];
      assign dma_req[s]  = (own_ep != '0) &&
                           (own_tx ? ep_tx_ready[own_ep] : ep_rx_ready[own_ep]);
    end
  endgenerate

  always_comb begin
    low_free = '0;
    for (int s = NSLOTS - 1; s >= 0; s--)
      if (free_vec[s]) low_free = SW'(s);
  end

  assign any_free = multi_mode ? |free_vec : (after_rel == '0);
  assign pick     = multi_mode ? low_free : '0;
  assign grant    = alloc_req && !bus_wr && (alloc_ep != '0) && any_free;

  always_comb begin
    map_d = after_rel;
    if (bus_wr) begin
      map_d = bus_wdata[MAPW-1:0];
    end else if (grant) begin
      for (int s = 0; s < NSLOTS; s++)
        if (pick == SW'(s)) map_d[s*FW +: FW] = {alloc_tx, alloc_ep};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_slot  <= '0;
      rel_err   <= 1'b0;
    end else begin
      map_q     <= map_d;
      rsp_valid <= alloc_req;
      rsp_ok    <= grant;
      rsp_slot  <= grant ? pick : '0;
      rel_err   <= rel_bad;
    end
  end

  generate
    if (DW > MAPW) begin : g_pad
      assign bus_rdata = {{(DW-MAPW){1'b0}}, map_q};
    end else begin : g_nopad
      assign bus_rdata = map_q;
    end
  endgenerate

endmodule

module dma_req_mapper_chk #(
  parameter int NSLOTS = 5,
  parameter int EPW    = 4,
  parameter int DW     = 32,
  localparam int FW    = EPW + 1,
  localparam int SW    = $clog2(NSLOTS),
  localparam int NEP   = 1 << EPW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              multi_mode,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_rdata,
  input logic              alloc_req,
  input logic [EPW-1:0]    alloc_ep,
  input logic              alloc_tx,
  input logic              rel_req,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic [SW-1:0]     rsp_slot,
  input logic              rel_err,
  input logic [NSLOTS-1:0] dma_req
);

  logic [FW-1:0] granted_field;
  assign granted_field = FW'(bus_rdata >> (FW * int'(rsp_slot)));

  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> (bus_rdata == '0 && !rsp_valid));

  p_grant_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |-> granted_field == {$past(alloc_tx), $past(alloc_ep)});

  p_refuse_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok && !$past(rel_req) && !$past(bus_wr)) |-> bus_rdata == $past(bus_rdata));

  p_ep0_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_ep == '0) |=> (rsp_valid && !rsp_ok));

  p_single_slot0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && !$past(multi_mode)) |-> rsp_slot == '0);

  p_single_err_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_err && !$past(multi_mode) && !$past(alloc_req) && !$past(bus_wr)) |-> bus_rdata == $past(bus_rdata));

  generate
    for (genvar s = 0; s < NSLOTS; s++) begin : g_req
      p_req_needs_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req[s] |-> bus_rdata[s*FW +: EPW] != '0);
    end
  endgenerate

endmodule

bind dma_req_mapper dma_req_mapper_chk #(.NSLOTS(NSLOTS), .EPW(EPW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .alloc_req(alloc_req), .alloc_ep(alloc_ep),
  .alloc_tx(alloc_tx), .rel_req(rel_req), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_slot(rsp_slot), .rel_err(rel_err), .dma_req(dma_req)
);

// File: tb/dma_req_mapper_tb.sv
module dma_req_mapper_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, multi_mode, bus_wr, alloc_req, alloc_tx, rel_req;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  alloc_ep, rel_ep;
  logic [2:0]  rel_slot, rsp_slot;
  logic        rsp_valid, rsp_ok, rel_err;
  logic [15:0] ep_tx_ready, ep_rx_ready;
  logic [4:0]  dma_req;

  dma_req_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alloc_req(alloc_req),
    .alloc_ep(alloc_ep), .alloc_tx(alloc_tx), .rel_req(rel_req),
    .rel_slot(rel_slot), .rel_ep(rel_ep), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_slot(rsp_slot), .rel_err(rel_err),
    .ep_tx_ready(ep_tx_ready), .ep_rx_ready(ep_rx_ready), .dma_req(dma_req)
  );

  int n_chk = 0, n_fail = 0;
  logic [24:0] mm;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_req(logic [24:0] m, logic [15:0] tr, logic [15:0] rr);
    logic [4:0] r;
    for (int s = 0; s < 5; s++) begin
      logic [3:0] ep;
      ep = m[s*5 +: 4];
      r[s] = (ep != 0) && (m[s*5+4] ? tr[ep] : rr[ep]);
    end
    return r;
  endfunction

  task automatic cycle(string tag, bit wr, logic [31:0] wd, bit al, logic [3:0] aep,
                       bit atx, bit rl, logic [2:0] rs, logic [3:0] rep);
    logic [24:0] nm;
    bit e_ok, e_err;
    logic [2:0] e_slot;
    bus_wr = wr; bus_wdata = wd; alloc_req = al; alloc_ep = aep; alloc_tx = atx;
    rel_req = rl; rel_slot = rs; rel_ep = rep;
    nm = mm; e_ok = 0; e_err = 0; e_slot = 0;
    if (wr) nm = wd[24:0];
    else begin
      if (rl) begin
        if (multi_mode) begin
          if (rs < 5) nm[int'(rs)*5 +: 5] = '0; else e_err = 1;
        end else if (mm[3:0] == rep) nm = '0;
        else e_err = 1;
      end
      if (al && aep != 0) begin
        if (multi_mode) begin
          for (int s = 4; s >= 0; s--)
            if (nm[s*5 +: 4] == 0) begin e_ok = 1; e_slot = 3'(s); end
        end else if (nm == 0) e_ok = 1;
        if (e_ok) nm[int'(e_slot)*5 +: 5] = {atx, aep};
      end
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; alloc_req = 0; rel_req = 0;
    mm = nm;
    chk({tag, " R4 rsp_valid"}, 32'(rsp_valid), 32'(al));
    chk({tag, " R5 rsp_ok"}, 32'(rsp_ok), 32'(e_ok));
    chk({tag, " R4 rsp_slot"}, 32'(rsp_slot), 32'(e_slot));
    chk({tag, " R7 rel_err"}, 32'(rel_err), 32'(e_err));
    chk({tag, " R3 map"}, bus_rdata, {7'd0, mm});
    chk({tag, " R10 dma_req"}, 32'(dma_req), 32'(exp_req(mm, ep_tx_ready, ep_rx_ready)));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; multi_mode = 1; bus_wr = 0; bus_wdata = 0; alloc_req = 0; alloc_ep = 0;
    alloc_tx = 0; rel_req = 0; rel_slot = 0; rel_ep = 0;
    ep_tx_ready = 16'hFFFF; ep_rx_ready = 16'hFFFF; mm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset map", bus_rdata, 32'd0);
    chk("R1 reset dma_req", 32'(dma_req), 32'd0);
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);

    cycle("R2 write", 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    chk("R1 upper bits zero", bus_rdata[31:25], 32'd0);
    cycle("R2 write wins", 1, 32'h0, 1, 4'd3, 1, 1, 3'd0, 0);
    chk("R2 alloc refused during write", 32'(rsp_ok), 32'd0);

    cycle("R4 first", 0, 0, 1, 4'd3, 1, 0, 0, 0);
    chk("R3 field tx ep3", bus_rdata, 32'h13);
    cycle("R4 second", 0, 0, 1, 4'd5, 0, 0, 0, 0);
    chk("R4 slot1", 32'(rsp_slot), 32'd1);
    cycle("R6 ep0 multi", 0, 0, 1, 4'd0, 1, 0, 0, 0);
    cycle("R4 fill2", 0, 0, 1, 4'd7, 1, 0, 0, 0);
    cycle("R4 fill3", 0, 0, 1, 4'd9, 0, 0, 0, 0);
    cycle("R4 fill4", 0, 0, 1, 4'd15, 1, 0, 0, 0);
    cycle("R5 full", 0, 0, 1, 4'd2, 0, 0, 0, 0);
    chk("R5 full refused", 32'(rsp_ok), 32'd0);
    cycle("R11 rel+alloc", 0, 0, 1, 4'd2, 0, 1, 3'd2, 0);
    chk("R11 freed slot granted", 32'(rsp_slot), 32'd2);
    cycle("R7 bad slot", 0, 0, 0, 0, 0, 1, 3'd6, 0);
    chk("R7 bad slot err", 32'(rel_err), 32'd1);
    cycle("R7 rel slot0", 0, 0, 0, 0, 0, 1, 3'd0, 0);
    ep_tx_ready = 16'h0; ep_rx_ready = 16'h0020;
    @(negedge clk);
    chk("R10 only rx ep5", 32'(dma_req), 32'b00010);
    ep_tx_ready = 16'h8000; ep_rx_ready = 16'h0;
    @(negedge clk);
    chk("R10 only tx ep15", 32'(dma_req), 32'b10000);

    multi_mode = 0;
    cycle("R8 clear", 1, 32'h0, 0, 0, 0, 0, 0, 0);
    cycle("R8 grant", 0, 0, 1, 4'd6, 1, 0, 0, 0);
    chk("R8 slot0 field", bus_rdata, 32'h16);
    cycle("R8 busy", 0, 0, 1, 4'd4, 0, 0, 0, 0);
    chk("R8 refused while nonzero", 32'(rsp_ok), 32'd0);
    cycle("R6 ep0 single", 0, 0, 1, 4'd0, 0, 0, 0, 0);
    cycle("R9 mismatch", 0, 0, 0, 0, 0, 1, 0, 4'd4);
    chk("R9 mismatch err", 32'(rel_err), 32'd1);
    cycle("R9 match", 0, 0, 0, 0, 0, 1, 0, 4'd6);
    chk("R9 match clears", bus_rdata, 32'd0);
    cycle("R8 wr slot1 busy", 1, 32'h0000_0040, 0, 0, 0, 0, 0, 0);
    cycle("R8 nonzero refuses", 0, 0, 1, 4'd1, 0, 0, 0, 0);

    for (int ph = 0; ph < 4; ph++) begin
      multi_mode = ph[0];
      for (int i = 0; i < 1000; i++) begin
        bit wr, al, rl;
        logic [3:0] rep;
        ep_tx_ready = 16'($urandom);
        ep_rx_ready = 16'($urandom);
        wr = ($urandom_range(0, 15) == 0);
        al = $urandom_range(0, 1) == 1;
        rl = ($urandom_range(0, 2) == 0);
        rep = $urandom_range(0, 1) == 1 ? mm[3:0] : 4'($urandom);
        cycle("R11 random", wr, $urandom, al, 4'($urandom), 1'($urandom),
              rl, 3'($urandom_range(0, 5)), rep);
      end
    end
    summary();
  end
endmodule